// File: doc/BRIEF.md
# Power-Sourcing Port Interrupt Aggregator

This block gathers hardware event pulses from a four-port power-sourcing controller into a single active-low interrupt line. Five event categories each have an 8-bit sticky register: power, detect/class, fault, startup and supply. An event bit is set by a one-cycle pulse on its input and stays set until software issues a global clear. Each category register is reduced to one or two summary bits, either per byte or per nibble. The eight summary bits form a read-only interrupt register.

Each summary bit passes through its own mask bit. A global enable bit then decides whether the surviving bits may drive the interrupt pin. The interrupt pin is driven by a two-state machine. QUIET is the released state, where `irq_n` is 1. ALERT is the asserted state, where `irq_n` is 0. The transition QUIET->ALERT (raise) happens on the edge after the global enable is 1 and some unmasked summary bit is 1. The transition ALERT->QUIET (drop) happens on the edge after that condition is no longer true. Otherwise the state holds (QUIET->QUIET idle, ALERT->ALERT hold).

A small synchronous register port gives software access to four locations: the summary, the mask, the global-enable configuration and the clear command. The mask's reset value depends on a configuration pin, which is sampled while reset is applied.

Top module: `pse_irq_agg`

## Requirements
- R1: An event input pulse sets the corresponding bit of its category register, and the bit stays set until a global clear or a reset.
- R2: Summary bit 0 is the OR of power-event bits [3:0] and bit 1 is the OR of power-event bits [7:4]. Bit 3 is the OR of detect/class bits [3:0] and bit 4 is the OR of detect/class bits [7:4].
- R3: Summary bit 5 is the OR of fault-event bits [3:0] and bit 2 is the OR of fault-event bits [7:4]. Bit 6 is the OR of all eight startup-event bits and bit 7 is the OR of all eight supply-event bits.
- R4: The mask register is at address 01h and is read/write. Mask bit n = 1 lets summary bit n drive the interrupt, and mask bit n = 0 blocks it.
- R5: The global enable is bit 7 of the configuration register at 17h, and the other bits of 17h read 0. While the global enable is 0, `irq_n` stays 1.
- R6: `irq_n` goes to 0 one clock after the global enable and some unmasked summary bit are both 1. It returns to 1 one clock after that condition ends.
- R7: Writing data with bit 7 = 1 to the command address 1Ah clears all five event registers, and with them the summary register, at that edge. A write to 1Ah with bit 7 = 0 has no effect.
- R8: If an event pulse and a clear command arrive in the same cycle, the pulsed bits end up set and all other bits end up cleared.
- R9: Reads of 1Ah return 00h.
- R10: A synchronous reset (`rst_n` = 0 at a clock edge) clears all event registers, so the summary at 00h reads 00h. It also clears the global enable, releases `irq_n` to 1, and loads the mask with {A,A,A,0,0,A,0,0} from bit 7 to bit 0, where A is `auto_cfg` at that edge.
- R11: The summary register at 00h is read-only, so writes to it are ignored. Reads of any address other than 00h, 01h and 17h return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_cfg | input | 1 | Pin that selects the default mask; sampled during reset |
| pwr_evt | input | 8 | Power event pulses: [3:0] enable change, [7:4] good change |
| dcl_evt | input | 8 | Detect/class pulses: [3:0] detection done, [7:4] classification done |
| flt_evt | input | 8 | Fault pulses: [3:0] current limit, [7:4] load disconnect |
| stu_evt | input | 8 | Startup-failure pulses |
| sup_evt | input | 8 | Supply-fault pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions take event inputs to be single-cycle pulses sampled at the clock edge. They also take `auto_cfg` to be held steady for the whole time reset is applied, so that the mask default is well defined. The stimulus changes every input one time unit after the rising edge, so each input is stable for the whole cycle. The stimulus holds `auto_cfg` constant around each reset pulse. Both directed and random phases issue at most one register write per cycle, and they keep the address bus at a mapped or deliberately unmapped value.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int EVT_W  = 8;
    localparam int HALF_W = EVT_W / 2;
    localparam int N_CAT  = 5;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int SUM_W  = 8;

    typedef enum logic [2:0] {
        CAT_PWR = 3'd0,
        CAT_DCL = 3'd1,
        CAT_FLT = 3'd2,
        CAT_STU = 3'd3,
        CAT_SUP = 3'd4
    } cat_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_ALERT = 1'b1
    } irq_state_e;

    localparam logic [ADDR_W-1:0] ADR_SUMMARY = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_MASK    = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_GCFG    = 8'h17;
    localparam logic [ADDR_W-1:0] ADR_CMD     = 8'h1A;

    localparam int CTL_BIT = 7;

    // summary bit positions
    localparam int B_PEN  = 0;
    localparam int B_PG   = 1;
    localparam int B_DISC = 2;
    localparam int B_DET  = 3;
    localparam int B_CLS  = 4;
    localparam int B_ILIM = 5;
    localparam int B_STU  = 6;
    localparam int B_SUP  = 7;

    function automatic logic [SUM_W-1:0] mask_default(input logic a);
        return {a, a, a, 1'b0, 1'b0, a, 1'b0, 1'b0};
    endfunction
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (clr ? '0 : q) | set;
    end

    // R1 / R8: pulsed bits are present after the edge, even alongside a clear
    p_set_sticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((q & $past(set)) == $past(set)));

    // R7: a clear with no concurrent set empties the register
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> (q == '0));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_agg_pkg::*;
(
    input  logic [N_CAT-1:0][EVT_W-1:0] evt,
    output logic [SUM_W-1:0]            sum
);
    always_comb begin
        sum         = '0;
        sum[B_PEN]  = |evt[CAT_PWR][HALF_W-1:0];
        sum[B_PG]   = |evt[CAT_PWR][EVT_W-1:HALF_W];
        sum[B_DET]  = |evt[CAT_DCL][HALF_W-1:0];
        sum[B_CLS]  = |evt[CAT_DCL][EVT_W-1:HALF_W];
        sum[B_ILIM] = |evt[CAT_FLT][HALF_W-1:0];
        sum[B_DISC] = |evt[CAT_FLT][EVT_W-1:HALF_W];
        sum[B_STU]  = |evt[CAT_STU];
        sum[B_SUP]  = |evt[CAT_SUP];
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_cfg,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SUM_W-1:0]  sum,
    output logic [DATA_W-1:0] rdata,
    output logic [SUM_W-1:0]  mask,
    output logic              gen,
    output logic              clr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= mask_default(auto_cfg);
            gen  <= 1'b0;
        end else if (wr) begin
            if (addr == ADR_MASK) mask <= wdata;
            if (addr == ADR_GCFG) gen  <= wdata[CTL_BIT];
        end
    end

    assign clr = wr && (addr == ADR_CMD) && wdata[CTL_BIT];

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADR_SUMMARY: rdata = sum;
            ADR_MASK:    rdata = mask;
            ADR_GCFG:    rdata[CTL_BIT] = gen;
            default:     rdata = '0;
        endcase
    end

    // R9: the command location never returns data
    p_cmd_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADR_CMD) |-> (rdata == '0));

    // R10: mask default reflects the configuration pin seen during reset
    p_mask_default_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask == mask_default($past(auto_cfg))));
endmodule

// File: rtl/pse_irq_agg.sv
module pse_irq_agg
    import irq_agg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        auto_cfg,
    input  logic [7:0]  pwr_evt,
    input  logic [7:0]  dcl_evt,
    input  logic [7:0]  flt_evt,
    input  logic [7:0]  stu_evt,
    input  logic [7:0]  sup_evt,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        irq_n
);
    logic [N_CAT-1:0][EVT_W-1:0] set_v;
    logic [N_CAT-1:0][EVT_W-1:0] evt_q;
    logic [SUM_W-1:0]            sum;
    logic [SUM_W-1:0]            mask;
    logic                        gen;
    logic                        clr;
    logic                        want;
    irq_state_e                  state, state_nx;

    assign set_v[CAT_PWR] = pwr_evt;
    assign set_v[CAT_DCL] = dcl_evt;
    assign set_v[CAT_FLT] = flt_evt;
    assign set_v[CAT_STU] = stu_evt;
    assign set_v[CAT_SUP] = sup_evt;

    for (genvar c = 0; c < N_CAT; c++) begin : g_cat
        irq_evt_latch #(.W(EVT_W)) u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_v[c]),
            .clr   (clr),
            .q     (evt_q[c])
        );
    end

    irq_summary u_sum (
        .evt (evt_q),
        .sum (sum)
    );

    irq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_cfg (auto_cfg),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .sum      (sum),
        .rdata    (reg_rdata),
        .mask     (mask),
        .gen      (gen),
        .clr      (clr)
    );

    assign want = gen && (|(sum & mask));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nx;
    end

    // next state: raise, drop, idle, hold
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_QUIET: state_nx = want ? ST_ALERT : ST_QUIET;
            ST_ALERT: state_nx = want ? ST_ALERT : ST_QUIET;
            default:  state_nx = ST_QUIET;
        endcase
    end

    // output
    always_comb begin
        irq_n = (state != ST_ALERT);
    end

    // R5: a disabled global enable keeps the pin released on the next cycle
    p_gen_off_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |=> irq_n);

    // R6: an unmasked, enabled source drives the pin low one cycle later
    p_alert_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gen && (|(sum & mask))) |=> !irq_n);
endmodule

// File: tb/tb_pse_irq_agg.sv
module tb_pse_irq_agg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_cfg = 1'b0;
    logic [7:0] pwr_evt = '0, dcl_evt = '0, flt_evt = '0, stu_evt = '0, sup_evt = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R10";
    bit model_ok = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_evt [5];
    logic [7:0] m_mask;
    logic       m_gen;
    logic       m_irq_n;

    pse_irq_agg dut (
        .clk(clk), .rst_n(rst_n), .auto_cfg(auto_cfg),
        .pwr_evt(pwr_evt), .dcl_evt(dcl_evt), .flt_evt(flt_evt),
        .stu_evt(stu_evt), .sup_evt(sup_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] m_summary();
        logic [7:0] s = '0;
        for (int b = 0; b < 8; b++) begin
            if (m_evt[0][b]) s[b < 4 ? 0 : 1] = 1'b1;   // power
            if (m_evt[1][b]) s[b < 4 ? 3 : 4] = 1'b1;   // detect/class
            if (m_evt[2][b]) s[b < 4 ? 5 : 2] = 1'b1;   // fault
            if (m_evt[3][b]) s[6] = 1'b1;               // startup
            if (m_evt[4][b]) s[7] = 1'b1;               // supply
        end
        return s;
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_summary();
            8'h01:   return m_mask;
            8'h17:   return {m_gen, 7'b0};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 5; c++) m_evt[c] = '0;
            m_gen   = 1'b0;
            m_mask  = {auto_cfg, auto_cfg, auto_cfg, 2'b00, auto_cfg, 2'b00};
            m_irq_n = 1'b1;
            model_ok = 1;
        end else begin
            logic clr_now;
            m_irq_n = !(m_gen && ((m_summary() & m_mask) != 0));
            clr_now = reg_wr && reg_addr == 8'h1A && reg_wdata[7];
            m_evt[0] = (clr_now ? 8'h00 : m_evt[0]) | pwr_evt;
            m_evt[1] = (clr_now ? 8'h00 : m_evt[1]) | dcl_evt;
            m_evt[2] = (clr_now ? 8'h00 : m_evt[2]) | flt_evt;
            m_evt[3] = (clr_now ? 8'h00 : m_evt[3]) | stu_evt;
            m_evt[4] = (clr_now ? 8'h00 : m_evt[4]) | sup_evt;
            if (reg_wr && reg_addr == 8'h01) m_mask = reg_wdata;
            if (reg_wr && reg_addr == 8'h17) m_gen = reg_wdata[7];
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_ok && !done) begin
            chk(cur_req, {7'b0, irq_n}, {7'b0, m_irq_n});
            chk(cur_req, reg_rdata, m_read(reg_addr));
        end
    end

    task automatic do_reset(input logic a);
        @(posedge clk); #1;
        auto_cfg = a; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input int cat, input logic [7:0] v);
        @(posedge clk); #1;
        case (cat)
            0: pwr_evt = v;
            1: dcl_evt = v;
            2: flt_evt = v;
            3: stu_evt = v;
            default: sup_evt = v;
        endcase
        @(posedge clk); #1;
        pwr_evt = '0; dcl_evt = '0; flt_evt = '0; stu_evt = '0; sup_evt = '0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(posedge clk);
        @(negedge clk);
        chk(tag, {7'b0, irq_n}, {7'b0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R10: reset defaults with the configuration pin high, then low
        cur_req = "R10";
        do_reset(1'b1);
        rd_chk(8'h01, 8'hE4, "R10");
        rd_chk(8'h00, 8'h00, "R10");
        rd_chk(8'h17, 8'h00, "R10");
        irq_chk(1'b1, "R10");
        do_reset(1'b0);
        rd_chk(8'h01, 8'h00, "R10");

        cur_req = "R4";
        do_write(8'h01, 8'hFF);
        rd_chk(8'h01, 8'hFF, "R4");
        cur_req = "R5";
        do_write(8'h17, 8'h80);
        rd_chk(8'h17, 8'h80, "R5");

        // R1 / R6: sticky event raises the pin one cycle later
        cur_req = "R6";
        pulse(0, 8'h04);
        rd_chk(8'h00, 8'h01, "R1");
        irq_chk(1'b0, "R6");

        cur_req = "R7";
        do_write(8'h1A, 8'h80);
        rd_chk(8'h00, 8'h00, "R7");
        irq_chk(1'b1, "R7");

        // R2 / R3: bit mapping per category and nibble
        cur_req = "R2";
        pulse(0, 8'h40); rd_chk(8'h00, 8'h02, "R2"); do_write(8'h1A, 8'h80);
        pulse(1, 8'h01); rd_chk(8'h00, 8'h08, "R2"); do_write(8'h1A, 8'h80);
        pulse(1, 8'h80); rd_chk(8'h00, 8'h10, "R2"); do_write(8'h1A, 8'h80);
        cur_req = "R3";
        pulse(2, 8'h02); rd_chk(8'h00, 8'h20, "R3"); do_write(8'h1A, 8'h80);
        pulse(2, 8'h20); rd_chk(8'h00, 8'h04, "R3"); do_write(8'h1A, 8'h80);
        pulse(3, 8'h08); rd_chk(8'h00, 8'h40, "R3"); do_write(8'h1A, 8'h80);
        pulse(4, 8'h10); rd_chk(8'h00, 8'h80, "R3"); do_write(8'h1A, 8'h80);

        // R4: masking one source
        cur_req = "R4";
        pulse(2, 8'h01);
        do_write(8'h01, 8'hDF);
        irq_chk(1'b1, "R4");
        do_write(8'h01, 8'h20);
        irq_chk(1'b0, "R4");

        // R5: global enable
        cur_req = "R5";
        do_write(8'h17, 8'h00);
        irq_chk(1'b1, "R5");
        do_write(8'h17, 8'h7F);
        irq_chk(1'b1, "R5");
        rd_chk(8'h17, 8'h00, "R5");
        do_write(8'h17, 8'h80);
        irq_chk(1'b0, "R5");

        // R7: command without bit 7 leaves events alone
        cur_req = "R7";
        do_write(8'h1A, 8'h7F);
        rd_chk(8'h00, 8'h20, "R7");

        // R8: set and clear in one cycle
        cur_req = "R8";
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = 8'h1A; reg_wdata = 8'h80; dcl_evt = 8'h10;
        @(posedge clk); #1;
        reg_wr = 1'b0; dcl_evt = '0;
        rd_chk(8'h00, 8'h10, "R8");

        // R9 / R11
        cur_req = "R9";
        rd_chk(8'h1A, 8'h00, "R9");
        cur_req = "R11";
        do_write(8'h00, 8'hFF);
        rd_chk(8'h00, 8'h10, "R11");
        rd_chk(8'h05, 8'h00, "R11");

        // random phase against the model
        cur_req = "R1";
        do_write(8'h1A, 8'h80);
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            pwr_evt = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
            dcl_evt = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
            flt_evt = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
            stu_evt = ($urandom % 9 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            sup_evt = ($urandom % 9 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            reg_wr = ($urandom % 5 == 0);
            case ($urandom % 6)
                0: reg_addr = 8'h00;
                1: reg_addr = 8'h01;
                2: reg_addr = 8'h17;
                3: reg_addr = 8'h1A;
                4: reg_addr = 8'h1A;
                default: reg_addr = 8'h33;
            endcase
            reg_wdata = 8'($urandom);
        end
        @(posedge clk); #1;
        pwr_evt = '0; dcl_evt = '0; flt_evt = '0; stu_evt = '0; sup_evt = '0; reg_wr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule